// File: doc/BRIEF.md
# Cyclic Converter Redundant Digit Combiner

This block is the digital back end of a cyclic, or algorithmic, analog-to-digital converter. The converter has a single stage. It compares the residue against two thresholds, subtracts the chosen reference, doubles the result and feeds it back to itself. Each pass gives one three-level decision (−1, 0 or +1). The block collects these decisions one per clock as they arrive, stores them, and adds them with binary weights to form a 12-bit output code.

The decision ranges overlap, so a comparator that trips a little early or late does not cause an error. A wrong decision in one step moves the residue in a way that later steps absorb, and the weighted sum is still exact. A conversion starts with a start strobe. Eleven redundant digits follow, then one final coarse digit. The code appears together with a one-cycle done pulse.

Top module: `cadc_digit_combiner`

## Requirements
- R1: While reset is asserted and after it is released, `result_o` is 0, `done_o` is 0 and `code_err_o` is 0.
- R2: Digit codes are 2'b00 = −1, 2'b01 = 0 and 2'b10 = +1. The code 2'b11 is illegal. An accepted illegal code counts as 0 and sets `code_err_o`, which stays set until the next start strobe and reads 0 in the cycle after that strobe.
- R3: A conversion is 12 accepted digits. Accepted digit i, for i = 1..11, has weight 2^(11−i). The 12th digit is the final coarse digit and has weight 1.
- R4: The code is 2048 plus the weighted digit sum, saturated to 0..4095. Twelve +1 digits give 4095, twelve −1 digits give 0, and twelve 0 digits give 2048.
- R5: `done_o` is high for exactly one cycle, the cycle after the clock edge that samples the 12th digit. `result_o` takes its new value in that same cycle and holds it until the next completion.
- R6: A start strobe clears the stored digits and the digit count. A conversion that is only partly received when the strobe arrives gives no done pulse. A digit presented in the same cycle as the strobe is dropped.
- R7: Digits presented before the first start strobe, or after the 12th digit of a conversion, are ignored. `done_o` stays 0 and `result_o` does not change.
- R8: Take an input in [−1, 1) and a stage whose comparator thresholds sit symmetrically at any level from 0 to 3/8 of the reference. The stage sets each final coarse digit to 0 for a non-negative last residue and to −1 for a negative one. The code then equals floor(2048·(input + 1)).
- R9: Idle cycles between digits, with the valid strobe low, do not change the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soc_i | input | 1 | Start-of-conversion strobe |
| dig_vld_i | input | 1 | Digit valid strobe |
| dig_i | input | 2 | Three-level digit code |
| result_o | output | 12 | Corrected output code |
| done_o | output | 1 | One-cycle completion pulse |
| code_err_o | output | 1 | An illegal code was accepted in this conversion |

## Verification
Single-digit patterns separate the weight of each position: a lone +1 in the first slot, a lone −1 in the last redundant slot, and a lone final coarse digit. Uniform +1, 0 and −1 patterns test the offset and both saturation limits. A behavioural cyclic stage makes digits from directed and pseudo-random inputs, including inputs exactly on and one step beyond each comparator threshold, for four threshold settings. These show whether the redundancy correction recovers the ideal code when the decisions differ from a plain binary search. Abort, late-digit, gapped and illegal-code sequences test the control behaviour apart from the arithmetic.

// File: rtl/cadc_pkg.sv
package cadc_pkg;

  localparam int DEF_BITS = 12;

  typedef enum logic [1:0] {
    DIG_NEG  = 2'b00,
    DIG_ZERO = 2'b01,
    DIG_POS  = 2'b10,
    DIG_BAD  = 2'b11
  } dig_code_e;

  // signed value of one three-level decision; the illegal code counts as zero
  function automatic int digit_val(input logic [1:0] c);
    case (c)
      DIG_NEG:  return -1;
      DIG_POS:  return 1;
      default:  return 0;
    endcase
  endfunction

  function automatic logic is_bad(input logic [1:0] c);
    return (c == DIG_BAD);
  endfunction

  // slot k < nsteps carries 2^(nsteps-1-k); the final coarse slot carries 1
  function automatic int digit_weight(input int k, input int nsteps);
    if (k < nsteps) return 1 << (nsteps - 1 - k);
    return 1;
  endfunction

  function automatic int code_offset(input int nbits);
    return 1 << (nbits - 1);
  endfunction

  function automatic int sat_code(input int s, input int nbits);
    int top;
    top = (1 << nbits) - 1;
    if (s < 0)   return 0;
    if (s > top) return top;
    return s;
  endfunction

endpackage

// File: rtl/cadc_seq_ctrl.sv
module cadc_seq_ctrl #(
  parameter int N_DIG = 12,
  parameter int CNT_W = $clog2(N_DIG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soc_i,
  input  logic             dig_vld_i,
  output logic             accept_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  // a start strobe wins over a digit in the same cycle
  assign accept_o = busy_q & dig_vld_i & ~soc_i;
  assign last_o   = accept_o & (cnt_q == CNT_W'(N_DIG - 1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (soc_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (accept_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cadc_digit_store.sv
module cadc_digit_store
  import cadc_pkg::*;
#(
  parameter int N_DIG = 12,
  parameter int CNT_W = $clog2(N_DIG + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soc_i,
  input  logic                  accept_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [1:0]            dig_i,
  output logic [N_DIG-1:0][1:0] view_o
);

  for (genvar k = 0; k < N_DIG; k++) begin : g_slot
    logic [1:0] slot_q;
    logic       hit;

    assign hit = accept_i & (cnt_i == CNT_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= DIG_ZERO;
      else if (soc_i)   slot_q <= DIG_ZERO;
      else if (hit)     slot_q <= dig_i;
    end

    // the digit arriving now is seen at once so the last one needs no extra cycle
    assign view_o[k] = hit ? dig_i : slot_q;
  end

endmodule

// File: rtl/cadc_rsd_adder.sv
module cadc_rsd_adder
  import cadc_pkg::*;
#(
  parameter int N_BITS  = DEF_BITS,
  parameter int N_STEPS = N_BITS - 1,
  parameter int N_DIG   = N_STEPS + 1
) (
  input  logic [N_DIG-1:0][1:0] view_i,
  output logic [N_BITS-1:0]     code_o
);

  int term [N_DIG];
  int sum;
  int clipped;

  for (genvar k = 0; k < N_DIG; k++) begin : g_term
    assign term[k] = digit_val(view_i[k]) * digit_weight(k, N_STEPS);
  end

  always_comb begin
    sum = code_offset(N_BITS);
    for (int k = 0; k < N_DIG; k++) sum = sum + term[k];
    clipped = sat_code(sum, N_BITS);
  end

  assign code_o = clipped[N_BITS-1:0];

endmodule

// File: rtl/cadc_digit_combiner.sv
module cadc_digit_combiner
  import cadc_pkg::*;
#(
  parameter int N_BITS = DEF_BITS,
  localparam int N_STEPS = N_BITS - 1,
  localparam int N_DIG   = N_STEPS + 1,
  localparam int CNT_W   = $clog2(N_DIG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soc_i,
  input  logic              dig_vld_i,
  input  logic [1:0]        dig_i,
  output logic [N_BITS-1:0] result_o,
  output logic              done_o,
  output logic              code_err_o
);

  logic                  accept_w;
  logic                  last_w;
  logic [CNT_W-1:0]      cnt_w;
  logic [N_DIG-1:0][1:0] view_w;
  logic [N_BITS-1:0]     raw_code_w;

  logic [N_BITS-1:0]     result_q;
  logic                  done_q;
  logic                  err_q;

  cadc_seq_ctrl #(.N_DIG(N_DIG), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soc_i     (soc_i),
    .dig_vld_i (dig_vld_i),
    .accept_o  (accept_w),
    .last_o    (last_w),
    .cnt_o     (cnt_w)
  );

  cadc_digit_store #(.N_DIG(N_DIG), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .soc_i    (soc_i),
    .accept_i (accept_w),
    .cnt_i    (cnt_w),
    .dig_i    (dig_i),
    .view_o   (view_w)
  );

  cadc_rsd_adder #(.N_BITS(N_BITS), .N_STEPS(N_STEPS), .N_DIG(N_DIG)) u_add (
    .view_i (view_w),
    .code_o (raw_code_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= last_w;
      if (last_w) result_q <= raw_code_w;
      if (soc_i)                            err_q <= 1'b0;
      else if (accept_w && is_bad(dig_i))   err_q <= 1'b1;
    end
  end

  assign result_o   = result_q;
  assign done_o     = done_q;
  assign code_err_o = err_q;

endmodule

// File: rtl/cadc_combiner_chk.sv
module cadc_combiner_chk #(
  parameter int N_DIG  = 12,
  parameter int CNT_W  = 4,
  parameter int N_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soc_i,
  input logic [1:0]        dig_i,
  input logic [N_BITS-1:0] result_o,
  input logic              done_o,
  input logic              code_err_o,
  input logic              accept_w,
  input logic              last_w,
  input logic [CNT_W-1:0]  cnt_w
);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> done_o);

  a_r5_done_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(last_w));

  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  a_r6_soc_blocks_done: assert property (@(posedge clk) disable iff (!rst_n)
    soc_i |=> !done_o);

  a_r6_soc_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    soc_i |=> (cnt_w == '0));

  a_r2_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soc_i |=> !code_err_o);

  a_r2_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && dig_i == 2'b11) |=> code_err_o);

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= CNT_W'(N_DIG));

  a_r7_no_accept_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_w == CNT_W'(N_DIG)) |-> !accept_w);

endmodule

bind cadc_digit_combiner cadc_combiner_chk #(
  .N_DIG(N_DIG), .CNT_W(CNT_W), .N_BITS(N_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soc_i      (soc_i),
  .dig_i      (dig_i),
  .result_o   (result_o),
  .done_o     (done_o),
  .code_err_o (code_err_o),
  .accept_w   (accept_w),
  .last_w     (last_w),
  .cnt_w      (cnt_w)
);

// File: tb/sim_cadc_digit_combiner.sv
module sim_cadc_digit_combiner;

  localparam int CLK_PERIOD = 10;
  localparam int S = 1 << 20;   // full-scale residue in model units

  typedef logic [1:0] code_arr_t [12];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soc_i = 1'b0;
  logic        dig_vld_i = 1'b0;
  logic [1:0]  dig_i = 2'b01;
  logic [11:0] result_o;
  logic        done_o;
  logic        code_err_o;

  int nvec  = 0;
  int nfail = 0;
  int ndone = 0;
  bit finished = 0;

  cadc_digit_combiner u0 (
    .clk(clk), .rst_n(rst_n), .soc_i(soc_i), .dig_vld_i(dig_vld_i),
    .dig_i(dig_i), .result_o(result_o), .done_o(done_o), .code_err_o(code_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (done_o) ndone++;

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ideal cyclic stage: gain two per step, thresholds at +/-thr
  task automatic model(input int vin, input int thr, output code_arr_t c, output int exp);
    int x;
    x = vin;
    for (int k = 0; k < 11; k++) begin
      if (x > thr)       begin c[k] = 2'b10; x = 2 * x - S; end
      else if (x < -thr) begin c[k] = 2'b00; x = 2 * x + S; end
      else               begin c[k] = 2'b01; x = 2 * x;     end
    end
    c[11] = (x >= 0) ? 2'b01 : 2'b00;
    exp = (vin + S) >>> 9;
    if (exp > 4095) exp = 4095;
  endtask

  task automatic fill(input logic [1:0] v, output code_arr_t c);
    for (int k = 0; k < 12; k++) c[k] = v;
  endtask

  // start strobe (a digit offered with it must be dropped, R6), twelve digits, then checks
  task automatic run_conv(input code_arr_t c, input int gap, input int exp, input string req);
    ndone = 0;
    @(posedge clk); #1 soc_i = 1'b1; dig_vld_i = 1'b1; dig_i = 2'b10;
    @(posedge clk); #1 soc_i = 1'b0;
    for (int k = 0; k < 12; k++) begin
      dig_vld_i = 1'b1; dig_i = c[k];
      @(posedge clk); #1;
      if (gap > 0 && k < 11) begin
        dig_vld_i = 1'b0; dig_i = 2'b10;
        repeat (gap) @(posedge clk);
        #1;
      end
    end
    dig_vld_i = 1'b0; dig_i = 2'b01;
    @(negedge clk);
    check({req, " code"}, int'(result_o), exp);
    check("R5 done after last digit", int'(done_o), 1);
    @(negedge clk);
    check("R5 done one cycle", int'(done_o), 0);
    check("R5 R6 single done per conversion", ndone, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 result in reset", int'(result_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 err after reset", int'(code_err_o), 0);
    // R7: digits before any start are ignored
    ndone = 0;
    for (int k = 0; k < 14; k++) begin
      @(posedge clk); #1 dig_vld_i = 1'b1; dig_i = 2'b10;
    end
    @(posedge clk); #1 dig_vld_i = 1'b0;
    @(negedge clk);
    check("R7 no done before start", ndone, 0);
    check("R7 result untouched before start", int'(result_o), 0);
  endtask

  task automatic t_uniform;
    code_arr_t c;
    fill(2'b01, c); run_conv(c, 0, 2048, "R4 all zero");
    fill(2'b10, c); run_conv(c, 0, 4095, "R4 all plus saturates");
    fill(2'b00, c); run_conv(c, 0, 0,    "R4 all minus");
  endtask

  task automatic t_weights;
    code_arr_t c;
    fill(2'b01, c); c[0]  = 2'b10; run_conv(c, 0, 3072, "R3 first slot weight");
    fill(2'b01, c); c[10] = 2'b00; run_conv(c, 0, 2047, "R3 last redundant weight");
    fill(2'b01, c); c[11] = 2'b10; run_conv(c, 0, 2049, "R3 coarse weight");
    fill(2'b01, c); c[4]  = 2'b10; c[5] = 2'b00; run_conv(c, 0, 2080, "R3 mixed signs");
  endtask

  task automatic t_model;
    code_arr_t c;
    int exp;
    int thr [4];
    int vins [12];
    logic [31:0] seed;
    thr[0] = 0; thr[1] = S / 8; thr[2] = S / 4; thr[3] = 3 * S / 8;
    vins[0] = 0;          vins[1] = S / 4;      vins[2] = -S / 4;
    vins[3] = S / 4 + 1;  vins[4] = -S / 4 - 1; vins[5] = S / 8;
    vins[6] = -S;         vins[7] = S - 1;      vins[8] = 1;
    vins[9] = -1;         vins[10] = S / 2;     vins[11] = 3 * S / 8;
    for (int t = 0; t < 4; t++)
      for (int v = 0; v < 12; v++) begin
        model(vins[v], thr[t], c, exp);
        run_conv(c, 0, exp, "R8 threshold vector");
      end
    seed = 32'h0000_1234;
    for (int n = 0; n < 24; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      model(int'(seed[30:10]) - S, thr[n % 4], c, exp);
      run_conv(c, 0, exp, "R8 random vector");
    end
  endtask

  task automatic t_gaps;
    code_arr_t c;
    int exp;
    model(S / 3, S / 4, c, exp);
    run_conv(c, 2, exp, "R9 gapped digits");
    model(-S / 5, S / 8, c, exp);
    run_conv(c, 1, exp, "R9 gapped digits");
  endtask

  task automatic t_illegal;
    code_arr_t c;
    fill(2'b01, c); c[3] = 2'b11;
    run_conv(c, 0, 2048, "R2 illegal counts as zero");
    check("R2 illegal flagged", int'(code_err_o), 1);
    @(posedge clk); #1 soc_i = 1'b1;
    @(posedge clk); #1 soc_i = 1'b0;
    @(negedge clk);
    check("R2 flag cleared by start", int'(code_err_o), 0);
  endtask

  task automatic t_abort;
    code_arr_t c;
    int prev;
    prev = int'(result_o);
    ndone = 0;
    @(posedge clk); #1 soc_i = 1'b1;
    @(posedge clk); #1 soc_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      dig_vld_i = 1'b1; dig_i = 2'b10;
      @(posedge clk); #1;
    end
    dig_vld_i = 1'b0;
    @(negedge clk);
    check("R6 no done on partial", ndone, 0);
    check("R6 result kept on partial", int'(result_o), prev);
    fill(2'b01, c); c[11] = 2'b00;
    run_conv(c, 0, 2047, "R6 restart discards partial digits");
  endtask

  task automatic t_late;
    code_arr_t c;
    fill(2'b01, c); c[1] = 2'b10;
    run_conv(c, 0, 2560, "R3 second slot weight");
    ndone = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1 dig_vld_i = 1'b1; dig_i = 2'b00;
    end
    @(posedge clk); #1 dig_vld_i = 1'b0;
    @(negedge clk);
    check("R7 no done on surplus digits", ndone, 0);
    check("R7 result kept on surplus digits", int'(result_o), 2560);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_uniform();
    t_weights();
    t_model();
    t_gaps();
    t_illegal();
    t_abort();
    t_late();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule